// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block turns bus addresses that land inside a graphics aperture window into physical addresses. For each page it walks two tables that software keeps in system memory. The first table is a page directory. Each of its 4-byte entries covers 4 MiB of address space and points to a second-level table page. Each second-level table page holds 1024 entries, one for each 4 KiB page, and each entry gives a physical page frame. Bit 0 marks an entry valid at both levels. A four-entry, fully associative translation cache keeps recent page results. Software can discard the whole cache with one register write.

Software programs the block through a small register port:
- offset 0x02: a 16-bit control register. Bit 2 switches the translation unit on.
- offset 0x04: the 32-bit directory base.
- offset 0x0C: a flush trigger. Writing a 1 in bit 0 starts a flush.
- offset 0x20: a 32-bit size register. Bits 3:1 select one of seven window sizes and bit 0 turns translation on.

The aperture base arrives as a 32-bit input and is aligned to the selected window size. The block accepts one request at a time. It answers each request with a one-cycle response pulse that carries either a physical address or a fault. It reads tables through a simple memory port that holds a read request until data returns.

Top module: `aperture_xlate`

## Requirements
- R1: After reset, `req_ready_o` is 1, `rsp_valid_o` and `mem_rd_valid_o` are 0, and every register reads 0.
- R2: The register port behaves as follows:
  - Offset 0x02 stores and returns bits 15:0.
  - Offset 0x04 stores and returns all 32 bits.
  - Offset 0x20 stores and returns all 32 bits.
  - Offset 0x0C always reads 0.
- R3: Translation is off unless both control bit 2 (offset 0x02) and size-register bit 0 are set. While it is off, a request returns its own address with no fault and no memory read, on the second rising edge counted from the acceptance edge.
- R4: The size code is size-register bits 3:1. Code k in 0..6 selects a window of 32 MiB shifted left by k, starting at the aperture base. Code 7 selects an empty window. A translated request outside the window faults with address 0 and no memory read, on the second edge counted from acceptance.
- R5: A cache miss has two reads:
  - It first reads the directory entry at {base[31:12], addr[31:22], 2'b00}.
  - It then reads the table entry at {dir[31:12], addr[21:12], 2'b00}.
  - The response is {pte[31:12], addr[11:0]}.
  - `mem_rd_addr_o` stays stable while a read waits for data.
- R6: A directory entry with bit 0 clear ends the walk after one read with a fault and address 0.
- R7: A second-level entry with bit 0 clear gives a fault and address 0 after two reads.
- R8: A request to a page already in the cache responds on the second edge counted from acceptance, with no memory read.
- R9: A faulting request does not fill the cache, so repeating it reads memory again.
- R10: The cache holds four pages and replaces them round-robin. After five distinct fills the first page misses and the third is still cached.
- R11: Writing 1 to bit 0 of offset 0x0C invalidates every cached page at once.
- R12: A flush that arrives while a walk is in progress does not stop that walk's response, which is still correct. The walk's result is not cached.
- R13: Only one request is in flight at a time. `req_ready_o` is low from acceptance until the response, and `rsp_valid_o` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aper_base_i | input | 32 | Aperture window base, aligned to the selected size |
| req_valid_i | input | 1 | Translation request valid |
| req_addr_i | input | 32 | Bus address to translate |
| req_ready_o | output | 1 | Block can accept a request |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_addr_o | output | 32 | Translated or passed-through address, 0 on fault |
| rsp_fault_o | output | 1 | Response is a fault |
| mem_rd_valid_o | output | 1 | Table read request, held until data returns |
| mem_rd_addr_o | output | 32 | Table read byte address |
| mem_rd_data_valid_i | input | 1 | Read data valid |
| mem_rd_data_i | input | 32 | Read data |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i`, combinational |

## Verification
A request is accepted on a rising edge. Pass-through answers, window faults and cache hits are due on the very next edge, which is the second edge counted from acceptance. The bench counts edges after acceptance and requires exactly one for these cases. A walk takes one extra edge per memory beat, so walk responses are awaited in a bounded loop instead. For walks, the number and the addresses of the table reads are checked against a software model of the tables. All outputs are sampled on falling edges, half a cycle after the edge that updates them.

// File: rtl/aptr_pkg.sv
package aptr_pkg;

    localparam int ADDR_W   = 32;
    localparam int PAGE_SH  = 12;
    localparam int DIR_SH   = 22;
    localparam int VPN_W    = ADDR_W - PAGE_SH;
    localparam int IDX_W    = DIR_SH - PAGE_SH;
    localparam int MIN_SH   = 25;

    localparam logic [7:0] OFF_CTRL  = 8'h02;
    localparam logic [7:0] OFF_BASE  = 8'h04;
    localparam logic [7:0] OFF_FLUSH = 8'h0C;
    localparam logic [7:0] OFF_SIZE  = 8'h20;
    localparam int         CTRL_EN_BIT = 2;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_LOOK,
        WK_DIR,
        WK_PTE
    } walk_st_t;

    typedef struct packed {
        logic             v;
        logic [VPN_W-1:0] vpn;
        logic [VPN_W-1:0] ppn;
    } tlb_ent_t;

    function automatic logic aptr_in_window(input logic [ADDR_W-1:0] a,
                                            input logic [ADDR_W-1:0] b,
                                            input logic [2:0]        code);
        logic [ADDR_W-1:0] msk;
        if (code == 3'd7) return 1'b0;
        msk = {ADDR_W{1'b1}} << (MIN_SH + int'(code));
        return ((a ^ b) & msk) == '0;
    endfunction

endpackage

// File: rtl/aptr_regs.sv
module aptr_regs
    import aptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [7:0]        addr_i,
    input  logic [ADDR_W-1:0] wdata_i,
    output logic [ADDR_W-1:0] rdata_o,
    output logic              unit_en_o,
    output logic [ADDR_W-1:0] tbl_base_o,
    output logic [2:0]        size_code_o,
    output logic              size_on_o,
    output logic              flush_o
);
    logic [15:0]       ctrl_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] size_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            base_q <= '0;
            size_q <= '0;
        end else if (wr_i) begin
            case (addr_i)
                OFF_CTRL: ctrl_q <= wdata_i[15:0];
                OFF_BASE: base_q <= wdata_i;
                OFF_SIZE: size_q <= wdata_i;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (addr_i)
            OFF_CTRL: rdata_o = {16'h0, ctrl_q};
            OFF_BASE: rdata_o = base_q;
            OFF_SIZE: rdata_o = size_q;
            default:  rdata_o = '0;
        endcase
    end

    assign flush_o     = wr_i && (addr_i == OFF_FLUSH) && wdata_i[0];
    assign unit_en_o   = ctrl_q[CTRL_EN_BIT];
    assign tbl_base_o  = base_q;
    assign size_code_o = size_q[3:1];
    assign size_on_o   = size_q[0];
endmodule

// File: rtl/aptr_tlb.sv
module aptr_tlb
    import aptr_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [VPN_W-1:0]   lk_vpn_i,
    output logic               hit_o,
    output logic [VPN_W-1:0]   hit_ppn_o,
    input  logic               fill_i,
    input  logic [VPN_W-1:0]   fill_vpn_i,
    input  logic [VPN_W-1:0]   fill_ppn_i,
    input  logic               flush_i,
    output logic [ENTRIES-1:0] vld_o
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    tlb_ent_t         ent_q [ENTRIES];
    logic [PTR_W-1:0] ptr_q;
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign match[g] = ent_q[g].v && (ent_q[g].vpn == lk_vpn_i);
        assign vld_o[g] = ent_q[g].v;

        always_ff @(posedge clk) begin
            if (rst || flush_i) begin
                ent_q[g] <= '0;
            end else if (fill_i && (ptr_q == PTR_W'(g))) begin
                ent_q[g] <= '{v: 1'b1, vpn: fill_vpn_i, ppn: fill_ppn_i};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            ptr_q <= '0;
        end else if (fill_i) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    always_comb begin
        hit_o     = |match;
        hit_ppn_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_ppn_o = ent_q[i].ppn;
        end
    end
endmodule

// File: rtl/aptr_walk.sv
module aptr_walk
    import aptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              req_ready_o,
    output logic [ADDR_W-1:0] cur_addr_o,
    input  logic              xl_on_i,
    input  logic              in_win_i,
    input  logic [ADDR_W-1:0] tbl_base_i,
    input  logic              tlb_hit_i,
    input  logic [VPN_W-1:0]  tlb_ppn_i,
    input  logic              flush_i,
    output logic              fill_o,
    output logic [VPN_W-1:0]  fill_vpn_o,
    output logic [VPN_W-1:0]  fill_ppn_o,
    output logic              mem_rd_valid_o,
    output logic [ADDR_W-1:0] mem_rd_addr_o,
    input  logic              mem_dv_i,
    input  logic [ADDR_W-1:0] mem_data_i,
    output logic              rsp_valid_o,
    output logic [ADDR_W-1:0] rsp_addr_o,
    output logic              rsp_fault_o
);
    walk_st_t          st_q;
    logic [ADDR_W-1:0] addr_q;
    logic [VPN_W-1:0]  tp_q;
    logic              discard_q;
    logic              rv_q, rf_q;
    logic [ADDR_W-1:0] ra_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= WK_IDLE;
            addr_q    <= '0;
            tp_q      <= '0;
            discard_q <= 1'b0;
            rv_q      <= 1'b0;
            rf_q      <= 1'b0;
            ra_q      <= '0;
        end else begin
            rv_q <= 1'b0;
            if (flush_i && st_q != WK_IDLE) discard_q <= 1'b1;
            case (st_q)
                WK_IDLE: if (req_valid_i) begin
                    addr_q    <= req_addr_i;
                    discard_q <= 1'b0;
                    st_q      <= WK_LOOK;
                end
                WK_LOOK: begin
                    if (!xl_on_i) begin
                        rv_q <= 1'b1; rf_q <= 1'b0; ra_q <= addr_q;
                        st_q <= WK_IDLE;
                    end else if (!in_win_i) begin
                        rv_q <= 1'b1; rf_q <= 1'b1; ra_q <= '0;
                        st_q <= WK_IDLE;
                    end else if (tlb_hit_i) begin
                        rv_q <= 1'b1; rf_q <= 1'b0;
                        ra_q <= {tlb_ppn_i, addr_q[PAGE_SH-1:0]};
                        st_q <= WK_IDLE;
                    end else begin
                        st_q <= WK_DIR;
                    end
                end
                WK_DIR: if (mem_dv_i) begin
                    if (!mem_data_i[0]) begin
                        rv_q <= 1'b1; rf_q <= 1'b1; ra_q <= '0;
                        st_q <= WK_IDLE;
                    end else begin
                        tp_q <= mem_data_i[ADDR_W-1:PAGE_SH];
                        st_q <= WK_PTE;
                    end
                end
                WK_PTE: if (mem_dv_i) begin
                    rv_q <= 1'b1;
                    rf_q <= !mem_data_i[0];
                    ra_q <= mem_data_i[0] ?
                            {mem_data_i[ADDR_W-1:PAGE_SH], addr_q[PAGE_SH-1:0]} : '0;
                    st_q <= WK_IDLE;
                end
                default: st_q <= WK_IDLE;
            endcase
        end
    end

    assign req_ready_o    = (st_q == WK_IDLE);
    assign cur_addr_o     = addr_q;
    assign mem_rd_valid_o = (st_q == WK_DIR) || (st_q == WK_PTE);
    assign mem_rd_addr_o  = (st_q == WK_DIR) ?
        {tbl_base_i[ADDR_W-1:PAGE_SH], addr_q[ADDR_W-1:DIR_SH], 2'b00} :
        {tp_q, addr_q[DIR_SH-1:PAGE_SH], 2'b00};

    assign fill_o     = (st_q == WK_PTE) && mem_dv_i && mem_data_i[0]
                        && !discard_q && !flush_i;
    assign fill_vpn_o = addr_q[ADDR_W-1:PAGE_SH];
    assign fill_ppn_o = mem_data_i[ADDR_W-1:PAGE_SH];

    assign rsp_valid_o = rv_q;
    assign rsp_addr_o  = ra_q;
    assign rsp_fault_o = rf_q;

    logic unused_walk;
    assign unused_walk = ^{tbl_base_i[PAGE_SH-1:0], mem_data_i[PAGE_SH-1:1]};
endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate
    import aptr_pkg::*;
#(
    parameter int TLB_ENTRIES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] aper_base_i,
    input  logic        req_valid_i,
    input  logic [31:0] req_addr_i,
    output logic        req_ready_o,
    output logic        rsp_valid_o,
    output logic [31:0] rsp_addr_o,
    output logic        rsp_fault_o,
    output logic        mem_rd_valid_o,
    output logic [31:0] mem_rd_addr_o,
    input  logic        mem_rd_data_valid_i,
    input  logic [31:0] mem_rd_data_i,
    input  logic        reg_wr_i,
    input  logic [7:0]  reg_addr_i,
    input  logic [31:0] reg_wdata_i,
    output logic [31:0] reg_rdata_o
);
    logic              unit_en, size_on, flush_w, xl_on, in_win;
    logic [2:0]        size_code;
    logic [ADDR_W-1:0] tbl_base, cur_addr;
    logic              tlb_hit, fill;
    logic [VPN_W-1:0]  tlb_ppn, fill_vpn, fill_ppn;
    logic [TLB_ENTRIES-1:0] tlb_vld_w;

    aptr_regs u_regs (
        .clk(clk), .rst(rst),
        .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
        .rdata_o(reg_rdata_o),
        .unit_en_o(unit_en), .tbl_base_o(tbl_base),
        .size_code_o(size_code), .size_on_o(size_on), .flush_o(flush_w)
    );

    assign xl_on  = unit_en && size_on;
    assign in_win = aptr_in_window(cur_addr, aper_base_i, size_code);

    aptr_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
        .clk(clk), .rst(rst),
        .lk_vpn_i(cur_addr[ADDR_W-1:PAGE_SH]),
        .hit_o(tlb_hit), .hit_ppn_o(tlb_ppn),
        .fill_i(fill), .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn),
        .flush_i(flush_w), .vld_o(tlb_vld_w)
    );

    aptr_walk u_walk (
        .clk(clk), .rst(rst),
        .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
        .req_ready_o(req_ready_o), .cur_addr_o(cur_addr),
        .xl_on_i(xl_on), .in_win_i(in_win), .tbl_base_i(tbl_base),
        .tlb_hit_i(tlb_hit), .tlb_ppn_i(tlb_ppn), .flush_i(flush_w),
        .fill_o(fill), .fill_vpn_o(fill_vpn), .fill_ppn_o(fill_ppn),
        .mem_rd_valid_o(mem_rd_valid_o), .mem_rd_addr_o(mem_rd_addr_o),
        .mem_dv_i(mem_rd_data_valid_i), .mem_data_i(mem_rd_data_i),
        .rsp_valid_o(rsp_valid_o), .rsp_addr_o(rsp_addr_o),
        .rsp_fault_o(rsp_fault_o)
    );
endmodule

// File: rtl/aperture_xlate_chk.sv
module aperture_xlate_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         req_valid_i,
    input logic         req_ready_o,
    input logic         rsp_valid_o,
    input logic         mem_rd_valid_o,
    input logic [31:0]  mem_rd_addr_o,
    input logic         mem_rd_data_valid_i,
    input logic         flush,
    input logic [N-1:0] tlb_vld
);
    assert_busy_no_accept_R13: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid_o |-> !req_ready_o);

    assert_accept_goes_busy_R13: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

    assert_rsp_single_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_o |=> !rsp_valid_o);

    assert_read_held_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid_o && !mem_rd_data_valid_i) |=>
            (mem_rd_valid_o && $stable(mem_rd_addr_o)));

    assert_flush_empties_R11: assert property (@(posedge clk) disable iff (rst)
        flush |=> (tlb_vld == '0));
endmodule

bind aperture_xlate aperture_xlate_chk #(.N(TLB_ENTRIES)) u_chk (
    .clk(clk), .rst(rst),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .rsp_valid_o(rsp_valid_o),
    .mem_rd_valid_o(mem_rd_valid_o), .mem_rd_addr_o(mem_rd_addr_o),
    .mem_rd_data_valid_i(mem_rd_data_valid_i),
    .flush(flush_w), .tlb_vld(tlb_vld_w)
);

// File: tb/aperture_xlate_bench.sv
module aperture_xlate_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] aper_base = 32'h4000_0000;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready, rsp_valid, rsp_fault, mem_rd_valid;
    logic [31:0] rsp_addr, mem_rd_addr;
    logic        mem_dv = 1'b0;
    logic [31:0] mem_data = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;

    int checks = 0;
    int failures = 0;
    logic [31:0] reads_total = '0;
    logic [31:0] rd_log [64];
    logic [31:0] mem [logic [31:0]];

    localparam logic [31:0] TBASE = 32'h0010_0000;

    always #2 clk = ~clk;

    aperture_xlate u_aperture_xlate (
        .clk(clk), .rst(rst), .aper_base_i(aper_base),
        .req_valid_i(req_valid), .req_addr_i(req_addr), .req_ready_o(req_ready),
        .rsp_valid_o(rsp_valid), .rsp_addr_o(rsp_addr), .rsp_fault_o(rsp_fault),
        .mem_rd_valid_o(mem_rd_valid), .mem_rd_addr_o(mem_rd_addr),
        .mem_rd_data_valid_i(mem_dv), .mem_rd_data_i(mem_data),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata)
    );

    function automatic logic [31:0] mrd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(negedge clk) begin
        if (mem_rd_valid && !mem_dv) begin
            mem_dv <= 1'b1;
            mem_data <= mrd(mem_rd_addr);
            rd_log[reads_total[5:0]] <= mem_rd_addr;
            reads_total <= reads_total + 1;
        end else begin
            mem_dv <= 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // page table helpers: directory at TBASE, table pages from 0x0020_0000
    task automatic map_dir(input logic [31:0] va);
        logic [31:0] tp;
        tp = 32'h0020_0000 + {10'h0, va[31:22], 12'h0};
        mem[{TBASE[31:12], va[31:22], 2'b00}] = tp | 32'h1;
    endtask

    task automatic map_page(input logic [31:0] va, input logic [31:0] pa);
        logic [31:0] tp;
        map_dir(va);
        tp = 32'h0020_0000 + {10'h0, va[31:22], 12'h0};
        mem[{tp[31:12], va[21:12], 2'b00}] = {pa[31:12], 12'h001};
    endtask

    // issue one request; lat counts edges after the acceptance edge
    task automatic xreq(input logic [31:0] a, output logic [31:0] pa,
                        output logic flt, output int lat, output int nrd,
                        output logic [31:0] r0, output logic [31:0] r1);
        logic [31:0] start;
        @(negedge clk);
        start = reads_total;
        req_valid = 1'b1; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        pa = '0; flt = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(posedge clk); lat++;
            @(negedge clk);
            if (i == 0 && !rsp_valid) chk("R13 ready low while busy", {31'h0, req_ready}, 32'h0);
            if (rsp_valid) break;
        end
        if (!rsp_valid) begin
            failures++; checks++;
            $display("FAIL R13 watchdog actual=no_rsp expected=rsp");
        end
        pa = rsp_addr; flt = rsp_fault;
        nrd = int'(reads_total - start);
        r0 = rd_log[start[5:0]];
        r1 = rd_log[start[5:0] + 6'd1];
    endtask

    logic [31:0] pa, r0, r1, d;
    logic        flt;
    int          lat, nrd;

    task automatic t_reset;
        chk("R1 ready", {31'h0, req_ready}, 32'h1);
        chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
        chk("R1 mem_rd_valid", {31'h0, mem_rd_valid}, 32'h0);
        reg_read(8'h04, d); chk("R1 base reg", d, 32'h0);
        reg_read(8'h20, d); chk("R1 size reg", d, 32'h0);
    endtask

    task automatic t_regs;
        reg_write(8'h02, 32'hABCD_1234);
        reg_read(8'h02, d); chk("R2 ctrl 16-bit", d, 32'h0000_1234);
        reg_write(8'h04, 32'hDEAD_BEEF);
        reg_read(8'h04, d); chk("R2 base", d, 32'hDEAD_BEEF);
        reg_write(8'h20, 32'h5A5A_A5A0);
        reg_read(8'h20, d); chk("R2 size", d, 32'h5A5A_A5A0);
        reg_read(8'h0C, d); chk("R2 flush reads 0", d, 32'h0);
    endtask

    task automatic t_passthru;
        reg_write(8'h02, 32'h0);
        reg_write(8'h20, 32'h1);
        xreq(32'h4000_1234, pa, flt, lat, nrd, r0, r1);
        chk("R3 addr ctrl off", pa, 32'h4000_1234);
        chk("R3 fault", {31'h0, flt}, 32'h0);
        chk("R3 latency", lat, 1);
        chk("R3 no reads", nrd, 0);
        reg_write(8'h02, 32'h4);
        reg_write(8'h20, 32'h0);
        xreq(32'h9000_0ABC, pa, flt, lat, nrd, r0, r1);
        chk("R3 addr size off", pa, 32'h9000_0ABC);
        chk("R3 no reads size off", nrd, 0);
    endtask

    task automatic t_walk_hit;
        reg_write(8'h04, TBASE);
        reg_write(8'h20, 32'h1);
        xreq(32'h4000_1234, pa, flt, lat, nrd, r0, r1);
        chk("R5 result", pa, 32'h9123_4234);
        chk("R5 fault", {31'h0, flt}, 32'h0);
        chk("R5 reads", nrd, 2);
        chk("R5 dir addr", r0, {TBASE[31:12], 10'h100, 2'b00});
        chk("R5 pte addr", r1, 32'h0030_0004);
        xreq(32'h4000_1FF0, pa, flt, lat, nrd, r0, r1);
        chk("R8 hit result", pa, 32'h9123_4FF0);
        chk("R8 hit latency", lat, 1);
        chk("R8 hit no reads", nrd, 0);
    endtask

    task automatic t_window;
        xreq(32'h4200_0000, pa, flt, lat, nrd, r0, r1);
        chk("R4 out 32M fault", {31'h0, flt}, 32'h1);
        chk("R4 out addr 0", pa, 32'h0);
        chk("R4 out latency", lat, 1);
        chk("R4 out no reads", nrd, 0);
        reg_write(8'h20, 32'h3);
        xreq(32'h4200_0000, pa, flt, lat, nrd, r0, r1);
        chk("R4 in 64M walks", nrd, 2);
        chk("R4 in 64M result", pa, 32'h8800_0000);
        reg_write(8'h20, 32'hB);
        xreq(32'h7FFF_F000, pa, flt, lat, nrd, r0, r1);
        chk("R4 in 1G reads", nrd, 1);
        xreq(32'h8000_0000, pa, flt, lat, nrd, r0, r1);
        chk("R4 out 1G no reads", nrd, 0);
        chk("R4 out 1G fault", {31'h0, flt}, 32'h1);
        reg_write(8'h20, 32'hF);
        xreq(32'h4000_1000, pa, flt, lat, nrd, r0, r1);
        chk("R4 code7 fault", {31'h0, flt}, 32'h1);
        chk("R4 code7 no reads", nrd, 0);
        reg_write(8'h20, 32'h1);
    endtask

    task automatic t_invalid;
        xreq(32'h4080_0000, pa, flt, lat, nrd, r0, r1);
        chk("R6 dir invalid fault", {31'h0, flt}, 32'h1);
        chk("R6 one read", nrd, 1);
        chk("R6 addr 0", pa, 32'h0);
        xreq(32'h4000_5000, pa, flt, lat, nrd, r0, r1);
        chk("R7 pte invalid fault", {31'h0, flt}, 32'h1);
        chk("R7 two reads", nrd, 2);
        xreq(32'h4000_5000, pa, flt, lat, nrd, r0, r1);
        chk("R9 fault not cached", nrd, 2);
    endtask

    task automatic t_rr;
        reg_write(8'h0C, 32'h1);
        for (int p = 0; p < 5; p++) begin
            xreq(32'h4000_0000 + 32'((p + 8) << 12), pa, flt, lat, nrd, r0, r1);
            chk("R10 fill walk", nrd, 2);
        end
        xreq(32'h4000_8000, pa, flt, lat, nrd, r0, r1);
        chk("R10 oldest evicted", nrd, 2);
        chk("R10 refill result", pa, 32'hA000_8000);
        xreq(32'h4000_A000, pa, flt, lat, nrd, r0, r1);
        chk("R10 third still cached", nrd, 0);
        chk("R10 third result", pa, 32'hA000_A000);
        reg_write(8'h0C, 32'h1);
        xreq(32'h4000_A000, pa, flt, lat, nrd, r0, r1);
        chk("R11 flush invalidates", nrd, 2);
        reg_write(8'h0C, 32'h0);
        xreq(32'h4000_A000, pa, flt, lat, nrd, r0, r1);
        chk("R11 write 0 no flush", nrd, 0);
    endtask

    task automatic t_flush_mid;
        int c;
        logic [31:0] start;
        @(negedge clk);
        start = reads_total;
        req_valid = 1'b1; req_addr = 32'h4000_D010;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        reg_wr = 1'b1; reg_addr = 8'h0C; reg_wdata = 32'h1;
        @(negedge clk);
        reg_wr = 1'b0;
        c = 0;
        while (!rsp_valid && c < 60) begin @(negedge clk); c++; end
        chk("R12 result despite flush", rsp_addr, 32'hA000_D010);
        chk("R12 fault", {31'h0, rsp_fault}, 32'h0);
        chk("R12 walked", reads_total - start, 32'd2);
        xreq(32'h4000_D020, pa, flt, lat, nrd, r0, r1);
        chk("R12 not cached", nrd, 2);
        xreq(32'h4000_D030, pa, flt, lat, nrd, r0, r1);
        chk("R12 later fill cached", nrd, 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) rd_log[i] = '0;
        map_page(32'h4000_1000, 32'h9123_4000);
        map_page(32'h4200_0000, 32'h8800_0000);
        map_dir(32'h4000_5000);
        for (int p = 8; p < 14; p++) map_page(32'h4000_0000 + 32'(p << 12), 32'hA000_0000 + 32'(p << 12));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_regs;
        t_passthru;
        t_walk_hit;
        t_window;
        t_invalid;
        t_rr;
        t_flush_mid;
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        failures++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule